// File: doc/BRIEF.md
# Parallel Master Bus Cycle Sequencer

This block drives an 8-bit external parallel bus as its master. A host hands it a read or write request, and the block runs a timed bus cycle: chip select and byte enable rise, a programmable setup wait follows, then a strobe pulse of programmable width, then a programmable hold. The host sets the timing through a configuration input. The block latches that configuration when it accepts a request, so the host may change the inputs while a cycle runs.

One host access moves one byte, or two bytes when the wide setting is on. In the wide case the low byte goes first and the high byte second, as two back-to-back bus cycles. An internal 11-bit bus address can stay where it is, count up or count down after every byte. The host loads this address directly while the block is idle.

The bus strobes come in one of two styles. The first style uses a separate read strobe and write strobe. The second uses a read/write direction pin plus a single enable strobe. The host sees busy, a one-cycle done pulse and an optional interrupt pulse, or a stall request that lasts through the access. Read bytes come back assembled on a 16-bit read data output.

Top module: `pbm_seq`

## Requirements
- R1: When the strobe field is nonzero, each byte cycle starts with a setup phase of (setup code + 1) clock cycles. In this phase chip select and byte enable are high and no strobe is active.
- R2: The strobe phase lasts (strobe code + 1) clock cycles.
- R3: When the strobe field is nonzero, a hold phase of (hold code + 1) cycles follows the strobe. Chip select stays high during hold and the strobe is low.
- R4: When the strobe field is 0000, each byte cycle is exactly one clock cycle long, with the strobe active. The setup and hold fields have no effect in this case.
- R5: After every byte cycle the bus address changes according to the step code: 00 keeps it, 01 adds 1 and 10 subtracts 1, wrapping modulo 2^11. Asserting addr_ld while idle loads addr_ld_val.
- R6: When the wide setting is 1, one access runs two byte cycles, low byte first and then high byte. When the wide setting is 0, an access runs one byte cycle.
- R7: With style 0, bus_rs is the read strobe and bus_ws is the write strobe. With style 1, bus_ws is the enable strobe for both directions, and bus_rs is the direction pin: 1 for a read and 0 for a write, held for the whole access. bus_rs is 0 when idle.
- R8: Interrupt code 01 pulses irq for one cycle after each byte cycle ends. Codes 00 and 11 give no irq. Code 10 gives no irq and holds stall high for exactly the busy cycles.
- R9: busy rises in the cycle after a request is accepted and falls after the last byte cycle. done pulses in the first idle cycle that follows. While idle, chip select, byte enable, strobes and output enable are all low.
- R10: The block ignores req and addr_ld while busy.
- R11: bus_doe is high for the whole of a write access and never during a read. bus_dout carries the byte of the current cycle: low byte first, then high byte.
- R12: Read data is sampled from bus_din on the clock edge that ends the strobe. The first byte lands in rdata[7:0] and clears rdata[15:8], and a second byte lands in rdata[15:8]. Writes leave rdata unchanged.
- R13: The configuration inputs are sampled when a request is accepted, and changes to them during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | 2 | Setup wait code |
| cfg_strobe | input | 4 | Extra strobe wait code |
| cfg_hold | input | 2 | Hold wait code |
| cfg_step | input | 2 | Address step code |
| cfg_wide | input | 1 | 1: two byte cycles per access |
| cfg_irq | input | 2 | Interrupt/stall code |
| cfg_style | input | 1 | Strobe style select |
| addr_ld | input | 1 | Load bus address (idle only) |
| addr_ld_val | input | 11 | Address to load |
| req | input | 1 | Access request |
| req_write | input | 1 | 1: write, 0: read |
| req_wdata | input | 16 | Write data, low byte sent first |
| busy | output | 1 | Access in progress |
| stall | output | 1 | Host stall request |
| done | output | 1 | Access finished pulse |
| irq | output | 1 | Per-byte interrupt pulse |
| rdata | output | 16 | Assembled read data |
| bus_cs | output | 1 | Chip select |
| bus_rs | output | 1 | Read strobe or direction pin |
| bus_ws | output | 1 | Write strobe or enable strobe |
| bus_be | output | 1 | Byte enable |
| bus_addr | output | 11 | Bus address |
| bus_dout | output | 8 | Data driven onto the bus |
| bus_din | input | 8 | Data read from the bus |
| bus_doe | output | 1 | Data output enable |

## Verification
The accesses cover both directions, both strobe styles and both widths. Some use long setup, strobe and hold codes, and some use the zero strobe code, which tells the three-phase timing apart from the one-cycle case. The bus model returns a byte derived from the address, so a wrong byte order, a wrong sampling edge or a wrong step direction shows up as a wrong rdata value. Other patterns change the configuration and fire requests and address loads in the middle of an access, to show that the block ignores them. A down-count from address zero exercises the wrap.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] STEP_KEEP = 2'd0;
  localparam logic [1:0] STEP_UP   = 2'd1;
  localparam logic [1:0] STEP_DOWN = 2'd2;

  localparam logic [1:0] IRQ_PULSE = 2'd1;
  localparam logic [1:0] IRQ_STALL = 2'd2;

  typedef struct packed {
    logic [1:0] setup;
    logic [3:0] strobe;
    logic [1:0] hold;
    logic [1:0] step;
    logic       wide;
    logic [1:0] irqm;
    logic       style;
  } cfg_t;
endpackage

// File: rtl/pbm_phase_ctrl.sv
module pbm_phase_ctrl
  import pbm_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] setup,
  input  logic [3:0] strobe,
  input  logic [1:0] hold,
  input  logic       wide,
  output phase_e     phase,
  output logic       hi,
  output logic       strobe_end,
  output logic       byte_end,
  output logic       last_end
);
  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_q, hi_d;
  logic          zero_mode;
  phase_e        first_ph;
  logic [CW-1:0] first_cnt;
  logic          more;

  always_comb begin
    zero_mode = (strobe == 4'd0);
    first_ph  = zero_mode ? PH_STROBE : PH_SETUP;
    first_cnt = zero_mode ? '0 : CW'(setup);
    more      = wide && !hi_q;
    state_d    = state_q;
    cnt_d      = cnt_q;
    hi_d       = hi_q;
    strobe_end = 1'b0;
    byte_end   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          state_d = first_ph;
          cnt_d   = first_cnt;
          hi_d    = 1'b0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          state_d = PH_STROBE;
          cnt_d   = CW'(strobe);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          strobe_end = 1'b1;
          if (zero_mode) begin
            byte_end = 1'b1;
          end else begin
            state_d = PH_HOLD;
            cnt_d   = CW'(hold);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) byte_end = 1'b1;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
    if (byte_end) begin
      if (more) begin
        state_d = first_ph;
        cnt_d   = first_cnt;
        hi_d    = 1'b1;
      end else begin
        state_d = PH_IDLE;
        hi_d    = 1'b0;
      end
    end
    last_end = byte_end && !more;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
    end
  end

  assign phase = state_q;
  assign hi    = hi_q;
endmodule

// File: rtl/pbm_addr_step.sv
module pbm_addr_step
  import pbm_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          step_en,
  input  logic [1:0]    step_mode,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (ld_en) begin
      addr_d  = ld_val;
      addr_en = 1'b1;
    end else if (step_en) begin
      addr_en = 1'b1;
      unique case (step_mode)
        STEP_UP:   addr_d = addr_q + 1'b1;
        STEP_DOWN: addr_d = addr_q - 1'b1;
        default:   addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_setup,
  input  logic [3:0]    cfg_strobe,
  input  logic [1:0]    cfg_hold,
  input  logic [1:0]    cfg_step,
  input  logic          cfg_wide,
  input  logic [1:0]    cfg_irq,
  input  logic          cfg_style,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  input  logic          req,
  input  logic          req_write,
  input  logic [WW-1:0] req_wdata,
  output logic          busy,
  output logic          stall,
  output logic          done,
  output logic          irq,
  output logic [WW-1:0] rdata,
  output logic          bus_cs,
  output logic          bus_rs,
  output logic          bus_ws,
  output logic          bus_be,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          bus_doe
);
  cfg_t          cfg_in, cfg_q, cfg_use;
  logic          we_q;
  logic [WW-1:0] wdata_q;
  logic [WW-1:0] rdata_q, rdata_d;
  logic          irq_q, done_q;
  logic          accept, idle;
  phase_e        phase;
  logic          hi, strobe_end, byte_end, last_end;
  logic          in_strobe;

  assign cfg_in  = '{setup: cfg_setup, strobe: cfg_strobe, hold: cfg_hold,
                     step: cfg_step, wide: cfg_wide, irqm: cfg_irq,
                     style: cfg_style};
  assign idle    = (phase == PH_IDLE);
  assign accept  = req && idle;
  assign cfg_use = idle ? cfg_in : cfg_q;

  pbm_phase_ctrl #(.CW(4)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .setup     (cfg_use.setup),
    .strobe    (cfg_use.strobe),
    .hold      (cfg_use.hold),
    .wide      (cfg_use.wide),
    .phase     (phase),
    .hi        (hi),
    .strobe_end(strobe_end),
    .byte_end  (byte_end),
    .last_end  (last_end)
  );

  pbm_addr_step #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (addr_ld && idle),
    .ld_val   (addr_ld_val),
    .step_en  (byte_end),
    .step_mode(cfg_q.step),
    .addr     (bus_addr)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (strobe_end && !we_q) begin
      if (hi) rdata_d[WW-1:DW] = bus_din;
      else    rdata_d = {{DW{1'b0}}, bus_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      cfg_q   <= cfg_in;
      we_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= byte_end && (cfg_q.irqm == IRQ_PULSE);
      done_q  <= last_end;
    end
  end

  assign in_strobe = (phase == PH_STROBE);
  assign busy      = !idle;
  assign stall     = busy && (cfg_q.irqm == IRQ_STALL);
  assign done      = done_q;
  assign irq       = irq_q;
  assign rdata     = rdata_q;
  assign bus_cs    = busy;
  assign bus_be    = busy;
  assign bus_doe   = busy && we_q;
  assign bus_dout  = hi ? wdata_q[WW-1:DW] : wdata_q[DW-1:0];
  assign bus_rs    = cfg_q.style ? (busy && !we_q) : (in_strobe && !we_q);
  assign bus_ws    = cfg_q.style ? in_strobe : (in_strobe && we_q);
endmodule

// File: rtl/pbm_seq_chk.sv
module pbm_seq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          stall,
  input logic          done,
  input logic          irq,
  input logic          addr_ld,
  input logic          bus_cs,
  input logic          bus_ws,
  input logic          bus_be,
  input logic          bus_doe,
  input logic [AW-1:0] bus_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_cs && !bus_be && !bus_ws && !bus_doe)); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_STALL_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy); // R8
  AST_IRQ_NOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !stall); // R8
  AST_DOE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_cs); // R11
  AST_ADDR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(addr_ld)) |-> $stable(bus_addr)); // R5
endmodule

bind pbm_seq pbm_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .stall   (stall),
  .done    (done),
  .irq     (irq),
  .addr_ld (addr_ld),
  .bus_cs  (bus_cs),
  .bus_ws  (bus_ws),
  .bus_be  (bus_be),
  .bus_doe (bus_doe),
  .bus_addr(bus_addr)
);

// File: tb/tb_pbm_seq.sv
`timescale 1ns/1ps
module tb_pbm_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_setup, cfg_hold, cfg_step, cfg_irq;
  logic [3:0]  cfg_strobe;
  logic        cfg_wide, cfg_style;
  logic        addr_ld;
  logic [10:0] addr_ld_val;
  logic        req, req_write;
  logic [15:0] req_wdata;
  logic        busy, stall, done, irq;
  logic [15:0] rdata;
  logic        bus_cs, bus_rs, bus_ws, bus_be, bus_doe;
  logic [10:0] bus_addr;
  logic [7:0]  bus_dout, bus_din;

  always #5 clk = ~clk;

  pbm_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .cfg_step(cfg_step), .cfg_wide(cfg_wide), .cfg_irq(cfg_irq),
    .cfg_style(cfg_style), .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .req(req), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .stall(stall), .done(done), .irq(irq), .rdata(rdata),
    .bus_cs(bus_cs), .bus_rs(bus_rs), .bus_ws(bus_ws), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_doe(bus_doe)
  );

  // external device model: byte depends on the address it is read at
  assign bus_din = bus_addr[7:0] ^ 8'h5A;

  typedef struct {
    bit        cs, rs, ws, doe, busy, stall, irq, done, rchk;
    bit [7:0]  dout;
    bit [10:0] addr;
    bit [15:0] rdata;
  } ent_t;

  ent_t      q[$];
  bit [10:0] addr_m;
  bit [15:0] rd_m;
  bit        last_busy;
  int        checks, errors;
  bit        finished;
  bit        m_we, m_style, m_pend;
  bit [1:0]  m_irqm;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] dev_byte(input bit [10:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic bit [10:0] step_addr(input bit [10:0] a, input bit [1:0] st);
    if (st == 2'd1) return a + 11'd1;
    if (st == 2'd2) return a - 11'd1;
    return a;
  endfunction

  task automatic push_busy(input bit strb, input bit [10:0] a, input bit [7:0] b);
    ent_t e;
    e = '{default: 0};
    e.cs = 1; e.busy = 1; e.addr = a; e.doe = m_we; e.dout = b;
    e.stall = (m_irqm == 2'd2);
    e.irq = m_pend; m_pend = 0;
    e.rs = m_style ? !m_we : (strb && !m_we);
    e.ws = m_style ? strb : (strb && m_we);
    q.push_back(e);
  endtask

  task automatic build(input bit we, input bit [15:0] wd, input bit [1:0] s,
                       input bit [3:0] m, input bit [1:0] h, input bit [1:0] st,
                       input bit wide, input bit [1:0] irqm, input bit style);
    bit [10:0] a;
    ent_t e;
    a = addr_m; m_we = we; m_style = style; m_irqm = irqm; m_pend = 0;
    for (int b = 0; b < (wide ? 2 : 1); b++) begin
      bit [7:0] by;
      by = (b == 1) ? wd[15:8] : wd[7:0];
      if (m == 0) begin
        push_busy(1, a, by);
      end else begin
        for (int i = 0; i <= s; i++) push_busy(0, a, by);
        for (int i = 0; i <= m; i++) push_busy(1, a, by);
        for (int i = 0; i <= h; i++) push_busy(0, a, by);
      end
      if (!we) begin
        if (b == 1) rd_m[15:8] = dev_byte(a);
        else rd_m = {8'h00, dev_byte(a)};
      end
      m_pend = (irqm == 2'd1);
      a = step_addr(a, st);
    end
    e = '{default: 0};
    e.addr = a; e.done = 1; e.irq = m_pend; e.rchk = 1; e.rdata = rd_m;
    q.push_back(e);
    addr_m = a;
  endtask

  task automatic tick();
    ent_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '{default: 0};
      e.addr = addr_m;
    end
    last_busy = e.busy;
    chk("R9 busy", busy, e.busy);
    chk("R9 done", done, e.done);
    chk("R1 cs", bus_cs, e.cs);
    chk("R1 be", bus_be, e.cs);
    chk("R7 rs", bus_rs, e.rs);
    chk("R7 ws", bus_ws, e.ws);
    chk("R11 doe", bus_doe, e.doe);
    if (e.doe) chk("R11 dout", bus_dout, e.dout);
    chk("R5 addr", bus_addr, e.addr);
    chk("R8 stall", stall, e.stall);
    chk("R8 irq", irq, e.irq);
    if (e.rchk) chk("R12 rdata", rdata, e.rdata);
  endtask

  task automatic issue(input bit we, input bit [15:0] wd, input bit [1:0] s,
                       input bit [3:0] m, input bit [1:0] h, input bit [1:0] st,
                       input bit wide, input bit [1:0] irqm, input bit style);
    cfg_setup = s; cfg_strobe = m; cfg_hold = h; cfg_step = st;
    cfg_wide = wide; cfg_irq = irqm; cfg_style = style;
    req = 1; req_write = we; req_wdata = wd;
    if (q.size() == 0 && !last_busy) build(we, wd, s, m, h, st, wide, irqm, style);
    tick();
    req = 0;
  endtask

  task automatic load(input bit [10:0] a);
    addr_ld = 1; addr_ld_val = a;
    if (q.size() == 0 && !last_busy) addr_m = a;
    tick();
    addr_ld = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = 0; req_write = 0; req_wdata = 0; addr_ld = 0; addr_ld_val = 0;
    cfg_setup = 0; cfg_strobe = 0; cfg_hold = 0; cfg_step = 0;
    cfg_wide = 0; cfg_irq = 0; cfg_style = 0;
    addr_m = 0; rd_m = 0; last_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state, idle outputs
    tick(); tick();
    // R1 R2 R3 R7 R8 R11: byte write, separate strobes, step up, irq pulse
    load(11'h010);
    issue(1, 16'h00C3, 2'd1, 4'd2, 2'd2, 2'd1, 0, 2'd1, 0);
    drain();
    // R4 R12 R5: single-cycle byte read, step down, setup/hold codes set but ignored
    issue(0, 16'h0, 2'd3, 4'd0, 2'd3, 2'd2, 0, 2'd1, 0);
    drain();
    // R6 R12 R7 R8: wide read, direction+enable style, stall mode
    load(11'h1FF);
    issue(0, 16'h0, 2'd3, 4'd5, 2'd0, 2'd1, 1, 2'd2, 1);
    drain();
    // R5 R6 R11: wide write, enable style, step down across address zero
    load(11'h000);
    issue(1, 16'hA55A, 2'd0, 4'd1, 2'd1, 2'd2, 1, 2'd1, 1);
    drain();
    // R10 R13: request, address load and config change in mid-access are ignored
    issue(1, 16'h3C96, 2'd2, 4'd3, 2'd1, 2'd1, 1, 2'd0, 0);
    tick();
    issue(0, 16'hFFFF, 2'd0, 4'd0, 2'd0, 2'd2, 0, 2'd1, 1);
    load(11'h555);
    drain();
    // R4 R5 R8: wide single-cycle write, address kept, irq code 11 silent
    issue(1, 16'h1234, 2'd2, 4'd0, 2'd2, 2'd0, 1, 2'd3, 0);
    drain();
    // R6 R12: byte read after wide read clears high half
    issue(0, 16'h0, 2'd0, 4'd1, 2'd0, 2'd1, 1, 2'd0, 0);
    drain();
    issue(0, 16'h0, 2'd1, 4'd1, 2'd1, 2'd1, 0, 2'd0, 1);
    drain();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule